// File: doc/BRIEF.md
# Event-Driven Timestamp and Event Log

This block keeps wall-clock time for a timing receiver. Incoming decoded event codes drive it. A 32-bit seconds value is built serially: one bit event arrives per second bit, and a reset event then moves the assembled value into the live seconds register. The same reset event clears a 32-bit sub-second counter. The counter can advance on one of three sources:
- the event clock divided by a 16-bit prescaler;
- rising edges of a distributed-bus bit;
- a dedicated tick event code.

A mapping stage upstream decides, per code, whether to assert two strobes. The latch strobe takes a snapshot of the current seconds and counter values into a pair of holding registers. The log strobe pushes a 72-bit entry into a 511-deep FIFO. The entry holds the seconds, the counter and the code. An external hardware input can also be logged as a pseudo-event. The host reads the head of the FIFO directly from the ports and pops it. A sticky flag reports entries that were lost because the FIFO was full.

Top module: `evt_tstamp_log`

## Requirements
- R1: An event with code 0x70 shifts the seconds shift register left and enters a 0 at bit 0. Code 0x71 does the same and enters a 1. After 32 such events, the first bit received sits at bit 31.
- R2: An event with code 0x7D copies the shift register into `sec_now` and sets `ts_now` to 0 on the next edge. It also restarts the prescaler from zero. The clear takes priority over any tick in the same cycle.
- R3: With `ts_src` = 0, `ts_now` advances once every D event-clock cycles, where D is `presc_div` (a value of 0 acts as 1). The first step after a reset event comes D cycles later.
- R4: With `ts_src` = 1, `ts_now` advances by one on each cycle where `bus_bit` is high and was low in the previous cycle.
- R5: With `ts_src` = 2, `ts_now` advances by one for each event with code 0x7C. With `ts_src` = 3, it holds.
- R6: When `map_latch` is high on an edge, `sec_latched` and `ts_latched` take the values that `sec_now` and `ts_now` had before that edge.
- R7: When `evt_valid` and `map_log` are both high, the FIFO stores one entry. The entry is {seconds in bits 71:40, counter in bits 39:8, code in bits 7:0}, with seconds and counter as they were before the edge. The oldest entry appears on `log_sec`, `log_ts` and `log_code` whenever `log_empty` is low. `host_pop` removes that entry, and entries leave in write order.
- R8: The FIFO holds at most 511 entries, and `log_level` reports the count. A write while full is discarded and sets `log_ovf`. `log_ovf` stays set until a cycle with `host_pop_ovf_clr` high and no new discarded write.
- R9: `ext_in` passes through a two-flop synchroniser. A rising edge seen while `ext_log_en` is high stores an entry with code 0xE0, three edges after the input rises. If a mapped log write happens in the same cycle, the external entry waits one cycle.
- R10: After reset, every value output and every count is 0, `log_empty` is 1, and `log_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A decoded event is present this cycle |
| evt_code | input | 8 | Decoded event code |
| map_latch | input | 1 | Snapshot strobe from mapping stage |
| map_log | input | 1 | Log-write strobe from mapping stage |
| bus_bit | input | 1 | Distributed-bus bit used as a counter source |
| ts_src | input | 2 | Counter source: 0 prescaler, 1 bus edge, 2 tick code, 3 hold |
| presc_div | input | 16 | Prescaler divide ratio |
| ext_in | input | 1 | Asynchronous external input |
| ext_log_en | input | 1 | Enables logging of external edges |
| host_pop | input | 1 | Remove FIFO head |
| host_pop_ovf_clr | input | 1 | Clear the overflow flag |
| sec_now | output | 32 | Live seconds register |
| ts_now | output | 32 | Live sub-second counter |
| sec_latched | output | 32 | Snapshot of seconds |
| ts_latched | output | 32 | Snapshot of counter |
| log_empty | output | 1 | FIFO holds no entry |
| log_level | output | 9 | FIFO occupancy |
| log_ovf | output | 1 | Sticky discarded-write flag |
| log_sec | output | 32 | Head entry seconds |
| log_ts | output | 32 | Head entry counter |
| log_code | output | 8 | Head entry code |

## Verification
The in-line properties check, on every cycle, that the counter holds unless the selected source ticks and that a reset event zeroes it. They also check that occupancy never exceeds the depth, that a write while full raises the overflow flag, and that the flag stays set until cleared. The serial assembly order of the seconds, the prescaler spacing, the snapshot values, the entry contents and their order, and the timing of the external pseudo-event can only be shown by the bench. It compares every output against a cycle model under random event traffic and under directed fills past the depth.

// File: rtl/evt_ts_pkg.sv
package evt_ts_pkg;
   typedef enum logic [1:0] {
      TS_SRC_PRESC = 2'd0,
      TS_SRC_BUS   = 2'd1,
      TS_SRC_CODE  = 2'd2,
      TS_SRC_HOLD  = 2'd3
   } ts_src_e;

   localparam logic [7:0] CODE_SHIFT0 = 8'h70;
   localparam logic [7:0] CODE_SHIFT1 = 8'h71;
   localparam logic [7:0] CODE_TICK   = 8'h7C;
   localparam logic [7:0] CODE_LOAD   = 8'h7D;
   localparam logic [7:0] CODE_EXT    = 8'hE0;
endpackage

// File: rtl/evt_ts_sync.sv
module evt_ts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evt_ts_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evt_ts_secshift.sv
module evt_ts_secshift #(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             shift_bit,
   input  logic             load,
   output logic [SEC_W-1:0] sec_q
);
   logic [SEC_W-1:0] shreg;

   generate
      if (SEC_W < 2) begin : g_bad_width
         $error("evt_ts_secshift: SEC_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         sec_q <= '0;
      end else begin
         if (shift_en) shreg <= {shreg[SEC_W-2:0], shift_bit};
         if (load)     sec_q <= shreg;
      end
   end
endmodule

// File: rtl/evt_ts_tickgen.sv
module evt_ts_tickgen
   import evt_ts_pkg::*;
#(
   parameter int PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         src,
   input  logic [PRESC_W-1:0] div,
   input  logic               restart,
   input  logic               bus_bit,
   input  logic               code_tick,
   output logic               tick
);
   logic [PRESC_W-1:0] pcnt;
   logic [PRESC_W-1:0] div_m1;
   logic               presc_tick;
   logic               bus_q;
   logic               bus_rise;

   generate
      if (PRESC_W < 1) begin : g_bad_presc
         $error("evt_ts_tickgen: PRESC_W must be positive");
      end
   endgenerate

   assign div_m1     = (div == '0) ? '0 : div - PRESC_W'(1);
   assign presc_tick = (pcnt >= div_m1);
   assign bus_rise   = bus_bit & ~bus_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pcnt  <= '0;
         bus_q <= 1'b0;
      end else begin
         bus_q <= bus_bit;
         if (restart || presc_tick) pcnt <= '0;
         else                       pcnt <= pcnt + PRESC_W'(1);
      end
   end

   always_comb begin
      unique case (ts_src_e'(src))
         TS_SRC_PRESC: tick = presc_tick;
         TS_SRC_BUS:   tick = bus_rise;
         TS_SRC_CODE:  tick = code_tick;
         default:      tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/evt_ts_fifo.sv
module evt_ts_fifo #(
   parameter int W     = 72,
   parameter int DEPTH = 511,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   input  logic          ovf_clr,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic [LW-1:0] level,
   output logic          ovf
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          full, wr_ok, rd_ok;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("evt_ts_fifo: DEPTH must be at least 2");
      end
   endgenerate

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign full  = (level == LW'(DEPTH));
   assign empty = (level == '0);
   assign wr_ok = push & ~full;
   assign rd_ok = pop & ~empty;
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
         ovf   <= 1'b0;
      end else begin
         if (wr_ok) wp <= nxt(wp);
         if (rd_ok) rp <= nxt(rp);
         unique case ({wr_ok, rd_ok})
            2'b10:   level <= level + LW'(1);
            2'b01:   level <= level - LW'(1);
            default: level <= level;
         endcase
         if (push && full) ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R8
   AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (push && level == LW'(DEPTH)) |=> ovf); // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf); // R8
   AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && level != '0) |=> level == $past(level) - LW'(1)); // R7
endmodule

// File: rtl/evt_tstamp_log.sv
module evt_tstamp_log
   import evt_ts_pkg::*;
#(
   parameter int         SEC_W       = 32,
   parameter int         TS_W        = 32,
   parameter int         PRESC_W     = 16,
   parameter int         FIFO_DEPTH  = 511,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] EXT_CODE    = CODE_EXT,
   localparam int        LVL_W       = $clog2(FIFO_DEPTH + 1),
   localparam int        ENT_W       = SEC_W + TS_W + 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic [7:0]         evt_code,
   input  logic               map_latch,
   input  logic               map_log,
   input  logic               bus_bit,
   input  logic [1:0]         ts_src,
   input  logic [PRESC_W-1:0] presc_div,
   input  logic               ext_in,
   input  logic               ext_log_en,
   input  logic               host_pop,
   input  logic               host_pop_ovf_clr,
   output logic [SEC_W-1:0]   sec_now,
   output logic [TS_W-1:0]    ts_now,
   output logic [SEC_W-1:0]   sec_latched,
   output logic [TS_W-1:0]    ts_latched,
   output logic               log_empty,
   output logic [LVL_W-1:0]   log_level,
   output logic               log_ovf,
   output logic [SEC_W-1:0]   log_sec,
   output logic [TS_W-1:0]    log_ts,
   output logic [7:0]         log_code
);
   logic             hit_shift, hit_load, hit_tick;
   logic             tick;
   logic             ext_s, ext_prev, ext_edge, ext_pend, ext_req;
   logic             ev_log, push;
   logic [ENT_W-1:0] din, dout;

   assign hit_shift = evt_valid && (evt_code[7:1] == CODE_SHIFT0[7:1]);
   assign hit_load  = evt_valid && (evt_code == CODE_LOAD);
   assign hit_tick  = evt_valid && (evt_code == CODE_TICK);

   evt_ts_secshift #(.SEC_W(SEC_W)) u_sec (
      .clk(clk), .rst_n(rst_n), .shift_en(hit_shift), .shift_bit(evt_code[0]),
      .load(hit_load), .sec_q(sec_now));

   evt_ts_tickgen #(.PRESC_W(PRESC_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .src(ts_src), .div(presc_div), .restart(hit_load),
      .bus_bit(bus_bit), .code_tick(hit_tick), .tick(tick));

   evt_ts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_in), .q(ext_s));

   assign ext_edge = ext_s & ~ext_prev & ext_log_en;
   assign ext_req  = ext_pend | ext_edge;
   assign ev_log   = evt_valid & map_log;
   assign push     = ev_log | ext_req;
   assign din      = {sec_now, ts_now, ev_log ? evt_code : EXT_CODE};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_now      <= '0;
         sec_latched <= '0;
         ts_latched  <= '0;
         ext_prev    <= 1'b0;
         ext_pend    <= 1'b0;
      end else begin
         if (hit_load)  ts_now <= '0;
         else if (tick) ts_now <= ts_now + TS_W'(1);
         if (map_latch) begin
            sec_latched <= sec_now;
            ts_latched  <= ts_now;
         end
         ext_prev <= ext_s;
         ext_pend <= ext_req & ev_log;
      end
   end

   evt_ts_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(din), .pop(host_pop),
      .ovf_clr(host_pop_ovf_clr), .dout(dout), .empty(log_empty),
      .level(log_level), .ovf(log_ovf));

   assign log_sec  = dout[ENT_W-1 -: SEC_W];
   assign log_ts   = dout[8 +: TS_W];
   assign log_code = dout[7:0];

   AST_TS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hit_load |=> ts_now == '0); // R2
   AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_load && !tick) |=> $stable(ts_now)); // R3
   AST_TS_NO_TICK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_src == 2'd3 && !hit_load) |=> $stable(ts_now)); // R5
endmodule

// File: tb/sim_evt_tstamp_log.sv
module sim_evt_tstamp_log;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        evt_valid = 0, map_latch = 0, map_log = 0, bus_bit = 0;
   logic [7:0]  evt_code = 0;
   logic [1:0]  ts_src = 0;
   logic [15:0] presc_div = 0;
   logic        ext_in = 0, ext_log_en = 0, host_pop = 0, ovf_clr = 0;
   logic [31:0] sec_now, ts_now, sec_latched, ts_latched, log_sec, log_ts;
   logic        log_empty, log_ovf;
   logic [8:0]  log_level;
   logic [7:0]  log_code;

   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   evt_tstamp_log u0 (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .map_latch(map_latch), .map_log(map_log), .bus_bit(bus_bit), .ts_src(ts_src),
      .presc_div(presc_div), .ext_in(ext_in), .ext_log_en(ext_log_en),
      .host_pop(host_pop), .host_pop_ovf_clr(ovf_clr), .sec_now(sec_now), .ts_now(ts_now),
      .sec_latched(sec_latched), .ts_latched(ts_latched), .log_empty(log_empty),
      .log_level(log_level), .log_ovf(log_ovf), .log_sec(log_sec), .log_ts(log_ts),
      .log_code(log_code));

   // cycle model built from the requirements
   logic [31:0] m_sh = 0, m_sec = 0, m_ts = 0, m_lsec = 0, m_lts = 0;
   logic [15:0] m_pc = 0;
   logic        m_busq = 0, m_s1 = 0, m_s2 = 0, m_sp = 0, m_pend = 0, m_ovf = 0;
   logic [71:0] q[$];

   task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      logic load, tick, ptick, evlog, extreq, edge_x, push;
      logic [15:0] dm1;
      logic [31:0] sh_o = m_sh, sec_o = m_sec, ts_o = m_ts;
      logic [71:0] ent;
      load  = evt_valid && evt_code == 8'h7D;
      dm1   = (presc_div == 0) ? 16'd0 : presc_div - 16'd1;
      ptick = (m_pc >= dm1);
      case (ts_src)
         2'd0: tick = ptick;
         2'd1: tick = bus_bit && !m_busq;
         2'd2: tick = evt_valid && evt_code == 8'h7C;
         default: tick = 0;
      endcase
      if (evt_valid && (evt_code == 8'h70 || evt_code == 8'h71)) m_sh = {sh_o[30:0], evt_code[0]};
      if (load) m_sec = sh_o;
      m_ts  = load ? 32'd0 : (tick ? ts_o + 1 : ts_o);
      m_pc  = (load || ptick) ? 16'd0 : m_pc + 16'd1;
      m_busq = bus_bit;
      if (map_latch) begin m_lsec = sec_o; m_lts = ts_o; end
      edge_x = m_s2 && !m_sp && ext_log_en;
      extreq = m_pend || edge_x;
      evlog  = evt_valid && map_log;
      push   = evlog || extreq;
      ent    = {sec_o, ts_o, evlog ? evt_code : 8'hE0};
      m_pend = extreq && evlog;
      m_sp = m_s2; m_s2 = m_s1; m_s1 = ext_in;
      if (host_pop && q.size() != 0) void'(q.pop_front());
      if (push) begin
         if (q.size() + (host_pop && q.size() != 0 ? 1 : 0) >= 511) m_ovf = 1;
         else q.push_back(ent);
      end else if (ovf_clr) m_ovf = 0;
      if (push && m_ovf && ovf_clr) m_ovf = 1;
   endtask

   task automatic compare_all();
      chk("R2 sec_now", {40'd0, sec_now}, {40'd0, m_sec});
      chk("R3 R4 R5 ts_now", {40'd0, ts_now}, {40'd0, m_ts});
      chk("R6 latches", {8'd0, sec_latched, ts_latched}, {8'd0, m_lsec, m_lts});
      chk("R8 level", {63'd0, log_level}, {63'd0, 9'(q.size())});
      chk("R8 ovf", {71'd0, log_ovf}, {71'd0, m_ovf});
      chk("R7 empty", {71'd0, log_empty}, {71'd0, q.size() == 0});
      if (q.size() != 0) chk("R7 head", {log_sec, log_ts, log_code}, q[0]);
   endtask

   task automatic step();
      model_edge();
      @(posedge clk);
      #1;
      compare_all();
   endtask

   task automatic idle();
      evt_valid = 0; map_latch = 0; map_log = 0; host_pop = 0; ovf_clr = 0;
   endtask

   task automatic send(logic [7:0] c);
      evt_valid = 1; evt_code = c; step(); evt_valid = 0;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] pat;
      void'($urandom(32'd20061406));
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk("R10 values", {8'd0, sec_now, ts_now}, 72'd0);
      chk("R10 latches", {8'd0, sec_latched, ts_latched}, 72'd0);
      chk("R10 fifo", {60'd0, log_empty, log_ovf, log_level, 1'b0}, {60'd0, 1'b1, 1'b0, 9'd0, 1'b0});
      rst_n = 1;
      ts_src = 2'd3;
      step();
      // R1: serial seconds, first bit lands at bit 31
      pat = 32'hA5C3_1E07;
      for (int i = 31; i >= 0; i--) send(pat[i] ? 8'h71 : 8'h70);
      send(8'h7D);
      chk("R1 assembled seconds", {40'd0, sec_now}, {40'd0, pat});
      chk("R2 ts cleared", {40'd0, ts_now}, 72'd0);
      // R3: divide by 3 from reset event
      ts_src = 2'd0; presc_div = 16'd3;
      send(8'h7D);
      repeat (9) step();
      chk("R3 div3 after 10 edges", {40'd0, ts_now}, 72'd3);
      presc_div = 16'd0;
      send(8'h7D);
      repeat (4) step();
      chk("R3 div0 acts as 1", {40'd0, ts_now}, 72'd4);
      // R4: bus edges
      ts_src = 2'd1; send(8'h7D);
      for (int i = 0; i < 5; i++) begin bus_bit = 1; step(); step(); bus_bit = 0; step(); end
      chk("R4 five rises", {40'd0, ts_now}, 72'd5);
      // R5: tick code
      ts_src = 2'd2; send(8'h7D);
      repeat (6) send(8'h7C);
      chk("R5 six tick codes", {40'd0, ts_now}, 72'd6);
      // R6 and R7: snapshot and log
      map_latch = 1; map_log = 1; send(8'h33); idle();
      chk("R6 snapshot ts", {40'd0, ts_latched}, 72'd6);
      chk("R7 entry", {log_sec, log_ts, log_code}, {pat, 32'd6, 8'h33});
      host_pop = 1; step(); idle();
      // R9: external pseudo-event
      ext_log_en = 1; ext_in = 1; step(); step();
      chk("R9 not yet logged", {63'd0, log_level}, 72'd0);
      step();
      chk("R9 logged code", {64'd0, log_code}, {64'd0, 8'hE0});
      ext_in = 0; host_pop = 1; step(); idle();
      // R9 collision: external edge and mapped write in the same cycle
      ext_in = 1; step(); step();
      map_log = 1; send(8'h44); idle();
      chk("R9 mapped first", {64'd0, log_code}, {64'd0, 8'h44});
      step();
      chk("R9 deferred entry", {63'd0, log_level}, 72'd2);
      ext_in = 0; host_pop = 1; step(); step(); idle();
      // R8: fill past depth
      map_log = 1; evt_valid = 1; evt_code = 8'h42;
      for (int i = 0; i < 520; i++) step();
      idle();
      chk("R8 full level", {63'd0, log_level}, 72'd511);
      chk("R8 overflow set", {71'd0, log_ovf}, 72'd1);
      step();
      chk("R8 ovf sticky", {71'd0, log_ovf}, 72'd1);
      ovf_clr = 1; step(); ovf_clr = 0;
      chk("R8 ovf cleared", {71'd0, log_ovf}, 72'd0);
      host_pop = 1;
      for (int i = 0; i < 515; i++) step();
      idle();
      // random traffic
      for (int i = 0; i < 8000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         evt_valid = ($urandom_range(0, 1) == 1);
         if (r < 20)      evt_code = 8'h70;
         else if (r < 40) evt_code = 8'h71;
         else if (r < 55) evt_code = 8'h7C;
         else if (r < 57) evt_code = 8'h7D;
         else             evt_code = 8'($urandom_range(0, 255));
         map_log   = ($urandom_range(0, 9) < 3);
         map_latch = ($urandom_range(0, 9) == 0);
         host_pop  = ($urandom_range(0, 9) < 4);
         ovf_clr   = ($urandom_range(0, 99) == 0);
         if ($urandom_range(0, 2) == 0) bus_bit = ~bus_bit;
         if ($urandom_range(0, 19) == 0) ext_in = ~ext_in;
         if (i % 500 == 0) begin
            ts_src    = 2'($urandom_range(0, 3));
            presc_div = 16'($urandom_range(0, 5));
            ext_log_en = ($urandom_range(0, 3) != 0);
         end
         step();
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule